// File: doc/BRIEF.md
# Speculative Packed Narrow-Operand Adder

This unit is a 32-bit integer adder that can finish two additions in one pass. Its carry chain can be cut at the midpoint, which turns it into two independent 16-bit adders. An addition can share the datapath when at least one of its two operands is narrow. A narrow operand is a 32-bit value whose upper half only repeats bit 15. The low half of the narrow operand is added to the low half of the other operand. The other operand's upper half is carried straight into the result. Slot 0 uses the low half of the datapath. Multiplexors move slot 1 into the upper half and route its sum back down.

Packing is speculative. A bit-16 carry that disagrees with the sign of the narrow operand shows that the upper half of the true sum would differ from the copied one. When this happens, both packed results return with their squash flags set, and the issue side replays them separately. In replay mode, and whenever packing is not possible, one operation runs over the full 32-bit chain. Results are registered and appear one cycle after acceptance.

Top module: `pna_pack_adder`

## Requirements
- R1: While rst_ni is low, done0_o, done1_o, squash0_o, squash1_o, wait1_o and ready_o are all 0. From the first clock edge after reset is released, ready_o is 1.
- R2: An operand is narrow exactly when bits 31 down to 15 are all equal. For example, 0xFFFF8000 is narrow, but 0x00008000 is not.
- R3: With replay_i low and both slot valids high, the two operations are packed when each one has a narrow operand. Packing sets done0_o and done1_o in the same cycle, and the carry does not cross bit 16.
- R4: A packed result without a squash equals a+b modulo 2^32 for its slot. Its upper half is the upper half of the slot's wide operand. The narrow operand is a if a is narrow, otherwise b.
- R5: A packed slot misspeculates in two cases. If its narrow operand has bit 15 = 0 and the 16-bit addition carries out, it misspeculates. If its narrow operand has bit 15 = 1 and the addition produces no carry, it also misspeculates.
- R6: A misspeculation in either packed slot sets both squash0_o and squash1_o.
- R7: If both slots are valid but they cannot be packed, slot 0 runs at full width and sets done0_o. Slot 1 is not executed, and wait1_o is set instead.
- R8: If only slot 1 is valid, it runs at full width. The unit sets done1_o, and res1_o = a1+b1 modulo 2^32.
- R9: With replay_i high, the lowest valid slot runs at full width and is never squashed. wait1_o is set if slot 1 is also valid but is not the one executed.
- R10: Outputs reflect an accepted input (valid_i and ready_o) one cycle later. A cycle without acceptance produces done0_o = done1_o = 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input slots carry a request |
| ready_o | output | 1 | Unit accepts requests |
| replay_i | input | 1 | Forces single full-width execution |
| slot0_vld_i | input | 1 | Slot 0 holds an addition |
| slot1_vld_i | input | 1 | Slot 1 holds an addition |
| a0_i | input | 32 | Slot 0 first operand |
| b0_i | input | 32 | Slot 0 second operand |
| a1_i | input | 32 | Slot 1 first operand |
| b1_i | input | 32 | Slot 1 second operand |
| done0_o | output | 1 | res0_o holds a slot 0 result |
| done1_o | output | 1 | res1_o holds a slot 1 result |
| res0_o | output | 32 | Slot 0 sum |
| res1_o | output | 32 | Slot 1 sum |
| squash0_o | output | 1 | Slot 0 result misspeculated |
| squash1_o | output | 1 | Slot 1 result misspeculated |
| wait1_o | output | 1 | Slot 1 was deferred, issue again |

## Verification
The stimulus covers four cases for packing:
- Both operands narrow, which shows that the segmented sums are correct.
- One narrow and one wide operand, which shows that the wide operand's upper half passes through.
- Carries into bit 16 in either direction, which separates a correct squash from a missed one for each slot and each sign.
- The case where both operands are narrow but of opposite sign, which pins down which operand is treated as narrow.

Boundary values around bit 15 (0x00008000 against 0xFFFF8000) check the narrowness test. Single-slot, non-packable and replay patterns check the full-width path, the deferral of slot 1 and the absence of squashes.

// File: rtl/pna_pkg.sv
package pna_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE   = 2'd0,
    MODE_PACK   = 2'd1,
    MODE_SINGLE = 2'd2
  } pna_mode_e;
endpackage

// File: rtl/pna_narrow_det.sv
module pna_narrow_det #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] val_i,
  output logic          narrow_o,
  output logic          neg_o
);
  localparam int HW = DW / 2;
  // narrow: bits DW-1..HW-1 are identical
  assign narrow_o = (val_i[DW-1:HW-1] == '0) || (val_i[DW-1:HW-1] == '1);
  assign neg_o    = val_i[HW-1];
endmodule

// File: rtl/pna_operand_pick.sv
module pna_operand_pick #(
  parameter int DW = 32
) (
  input  logic [DW-1:0]   a_i,
  input  logic [DW-1:0]   b_i,
  output logic            pack_ok_o,
  output logic [DW/2-1:0] nar_lo_o,
  output logic [DW-1:0]   wide_o,
  output logic            nar_neg_o
);
  localparam int HW = DW / 2;

  logic a_nar, b_nar, a_neg, b_neg;

  pna_narrow_det #(.DW(DW)) u_det_a (.val_i(a_i), .narrow_o(a_nar), .neg_o(a_neg));
  pna_narrow_det #(.DW(DW)) u_det_b (.val_i(b_i), .narrow_o(b_nar), .neg_o(b_neg));

  assign pack_ok_o = a_nar | b_nar;

  always_comb begin
    if (a_nar) begin
      nar_lo_o  = a_i[HW-1:0];
      nar_neg_o = a_neg;
      wide_o    = b_i;
    end else begin
      nar_lo_o  = b_i[HW-1:0];
      nar_neg_o = b_neg;
      wide_o    = a_i;
    end
  end
endmodule

// File: rtl/pna_seg_adder.sv
module pna_seg_adder #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] x_i,
  input  logic [DW-1:0] y_i,
  input  logic          split_i,
  output logic [DW-1:0] sum_o,
  output logic          c_lo_o,
  output logic          c_hi_o
);
  localparam int HW = DW / 2;

  logic [HW:0] lo_sum, hi_sum;
  logic        hi_cin;

  assign lo_sum = {1'b0, x_i[HW-1:0]} + {1'b0, y_i[HW-1:0]};
  assign hi_cin = split_i ? 1'b0 : lo_sum[HW];
  assign hi_sum = {1'b0, x_i[DW-1:HW]} + {1'b0, y_i[DW-1:HW]} + {{HW{1'b0}}, hi_cin};

  assign sum_o  = {hi_sum[HW-1:0], lo_sum[HW-1:0]};
  assign c_lo_o = lo_sum[HW];
  assign c_hi_o = hi_sum[HW];

  // R3
  always_comb begin
    seg_cut_chk: assert (!split_i || (sum_o[DW-1:HW] == HW'(x_i[DW-1:HW] + y_i[DW-1:HW])));
  end
endmodule

// File: rtl/pna_pack_adder.sv
module pna_pack_adder
  import pna_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  output logic          ready_o,
  input  logic          replay_i,
  input  logic          slot0_vld_i,
  input  logic          slot1_vld_i,
  input  logic [DW-1:0] a0_i,
  input  logic [DW-1:0] b0_i,
  input  logic [DW-1:0] a1_i,
  input  logic [DW-1:0] b1_i,
  output logic          done0_o,
  output logic          done1_o,
  output logic [DW-1:0] res0_o,
  output logic [DW-1:0] res1_o,
  output logic          squash0_o,
  output logic          squash1_o,
  output logic          wait1_o
);
  localparam int HW    = DW / 2;
  localparam int SLOTS = 2;

  logic [DW-1:0] a_s [SLOTS];
  logic [DW-1:0] b_s [SLOTS];
  logic [DW-1:0] wide [SLOTS];
  logic [HW-1:0] nar_lo [SLOTS];
  logic [SLOTS-1:0] pk_ok, nar_neg;

  assign a_s[0] = a0_i;
  assign b_s[0] = b0_i;
  assign a_s[1] = a1_i;
  assign b_s[1] = b1_i;

  for (genvar g = 0; g < SLOTS; g++) begin : g_pick
    pna_operand_pick #(.DW(DW)) u_pick (
      .a_i      (a_s[g]),
      .b_i      (b_s[g]),
      .pack_ok_o(pk_ok[g]),
      .nar_lo_o (nar_lo[g]),
      .wide_o   (wide[g]),
      .nar_neg_o(nar_neg[g])
    );
  end

  pna_mode_e     mode;
  logic          sel1, split, c_lo, c_hi, acc;
  logic [DW-1:0] add_x, add_y, sum;

  always_comb begin
    mode = MODE_IDLE;
    if (!replay_i && slot0_vld_i && slot1_vld_i && (&pk_ok)) mode = MODE_PACK;
    else if (slot0_vld_i || slot1_vld_i)                      mode = MODE_SINGLE;
  end

  assign sel1  = !slot0_vld_i;
  assign split = (mode == MODE_PACK);

  // operand routing: slot 1 shifted into upper half when packed
  always_comb begin
    if (split) begin
      add_x = {nar_lo[1], nar_lo[0]};
      add_y = {wide[1][HW-1:0], wide[0][HW-1:0]};
    end else begin
      add_x = sel1 ? a1_i : a0_i;
      add_y = sel1 ? b1_i : b0_i;
    end
  end

  pna_seg_adder #(.DW(DW)) u_add (
    .x_i    (add_x),
    .y_i    (add_y),
    .split_i(split),
    .sum_o  (sum),
    .c_lo_o (c_lo),
    .c_hi_o (c_hi)
  );

  logic          d0_n, d1_n, sq_n, w_n;
  logic [DW-1:0] r0_n, r1_n;

  always_comb begin
    d0_n = 1'b0;
    d1_n = 1'b0;
    sq_n = 1'b0;
    w_n  = 1'b0;
    r0_n = sum;
    r1_n = sum;
    unique case (mode)
      MODE_PACK: begin
        d0_n = 1'b1;
        d1_n = 1'b1;
        r0_n = {wide[0][DW-1:HW], sum[HW-1:0]};
        r1_n = {wide[1][DW-1:HW], sum[DW-1:HW]};
        // carry must match the narrow operand's sign
        sq_n = (c_lo ^ nar_neg[0]) | (c_hi ^ nar_neg[1]);
      end
      MODE_SINGLE: begin
        if (sel1) d1_n = 1'b1;
        else begin
          d0_n = 1'b1;
          w_n  = slot1_vld_i;
        end
      end
      default: ;
    endcase
  end

  assign acc = valid_i & ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_o   <= 1'b0;
      done0_o   <= 1'b0;
      done1_o   <= 1'b0;
      squash0_o <= 1'b0;
      squash1_o <= 1'b0;
      wait1_o   <= 1'b0;
      res0_o    <= '0;
      res1_o    <= '0;
    end else begin
      ready_o   <= 1'b1;
      done0_o   <= acc & d0_n;
      done1_o   <= acc & d1_n;
      squash0_o <= acc & sq_n;
      squash1_o <= acc & sq_n;
      wait1_o   <= acc & w_n;
      if (acc) begin
        res0_o <= r0_n;
        res1_o <= r1_n;
      end
    end
  end

  // R4
  sum_match0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> (!done0_o || squash0_o || res0_o == $past(a0_i + b0_i)));
  // R4
  sum_match1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> (!done1_o || squash1_o || res1_o == $past(a1_i + b1_i)));
  // R6
  squash_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    squash0_o == squash1_o);
  // R9
  replay_clean_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && replay_i) |=> (!squash0_o && !squash1_o));
  // R7
  wait_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait1_o |-> (done0_o && !done1_o));
  // R10
  idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc |=> (!done0_o && !done1_o));
endmodule

// File: tb/pna_pack_adder_test.sv
module pna_pack_adder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0, replay = 1'b0, v0 = 1'b0, v1 = 1'b0;
  logic [31:0] a0 = '0, b0 = '0, a1 = '0, b1 = '0;
  logic        ready, d0, d1, sq0, sq1, w1;
  logic [31:0] r0, r1;
  int          total = 0, bad = 0;

  always #2 clk = ~clk;

  pna_pack_adder uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .ready_o(ready),
    .replay_i(replay), .slot0_vld_i(v0), .slot1_vld_i(v1),
    .a0_i(a0), .b0_i(b0), .a1_i(a1), .b1_i(b1),
    .done0_o(d0), .done1_o(d1), .res0_o(r0), .res1_o(r1),
    .squash0_o(sq0), .squash1_o(sq1), .wait1_o(w1)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic        rp, sv0, sv1;
    logic [31:0] ia0, ib0, ia1, ib1;
    logic        ed0, ed1, esq, ew;
    logic [31:0] er0, er1;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    // R3 R4: both narrow, slot1 negative with carry
    '{4'd3, 1'b0,1'b1,1'b1, 32'h5, 32'h7, 32'hFFFF_FFFF, 32'h3, 1'b1,1'b1,1'b0,1'b0, 32'hC, 32'h2},
    // R4: narrow plus wide, upper half passed through
    '{4'd4, 1'b0,1'b1,1'b1, 32'h10, 32'h1234_5678, 32'hABCD_0005, 32'hFFFF_FFFE, 1'b1,1'b1,1'b0,1'b0, 32'h1234_5688, 32'hABCD_0003},
    // R5 R6: slot0 positive narrow carries out
    '{4'd5, 1'b0,1'b1,1'b1, 32'h7FFF, 32'h0001_8001, 32'h1, 32'h1, 1'b1,1'b1,1'b1,1'b0, 32'h0, 32'h0},
    // R5 R6: slot1 negative narrow without carry
    '{4'd6, 1'b0,1'b1,1'b1, 32'h1, 32'h2, 32'hABCD_0001, 32'hFFFF_FFFE, 1'b1,1'b1,1'b1,1'b0, 32'h0, 32'h0},
    // R7: slot0 not packable
    '{4'd7, 1'b0,1'b1,1'b1, 32'h1234_5678, 32'h1111_1111, 32'h1, 32'h2, 1'b1,1'b0,1'b0,1'b1, 32'h2345_6789, 32'h0},
    // R8: only slot1, full-width wrap
    '{4'd8, 1'b0,1'b0,1'b1, 32'h0, 32'h0, 32'h8000_0000, 32'h8000_0001, 1'b0,1'b1,1'b0,1'b0, 32'h0, 32'h1},
    // R9: replay of a pattern that would squash when packed
    '{4'd9, 1'b1,1'b1,1'b1, 32'h7FFF, 32'h0001_8001, 32'h1, 32'h1, 1'b1,1'b0,1'b0,1'b1, 32'h0002_0000, 32'h0},
    // R2: 0x00008000 is wide
    '{4'd2, 1'b0,1'b1,1'b1, 32'h8000, 32'h0001_0000, 32'h1, 32'h1, 1'b1,1'b0,1'b0,1'b1, 32'h0001_8000, 32'h0},
    // R2 R5: 0xFFFF8000 is narrow and negative, no carry
    '{4'd2, 1'b0,1'b1,1'b1, 32'hFFFF_8000, 32'h0002_0000, 32'h2, 32'h3, 1'b1,1'b1,1'b1,1'b0, 32'h0, 32'h0},
    // R7: only slot0 valid, no wait
    '{4'd7, 1'b0,1'b1,1'b0, 32'h3, 32'h4, 32'h0, 32'h0, 1'b1,1'b0,1'b0,1'b0, 32'h7, 32'h0},
    // R10: no slot valid
    '{4'd10, 1'b0,1'b0,1'b0, 32'h3, 32'h4, 32'h5, 32'h6, 1'b0,1'b0,1'b0,1'b0, 32'h0, 32'h0},
    // R4 R5: a narrow positive chosen over b narrow negative, squash
    '{4'd5, 1'b0,1'b1,1'b1, 32'h1, 32'hFFFF_FFFF, 32'h0, 32'h0, 1'b1,1'b1,1'b1,1'b0, 32'h0, 32'h0}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    bad++;
    $display("FAIL R10 watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1 reset state
    chk({d0, d1, sq0, sq1, w1, ready} == 6'b0, "R1 reset outputs", {26'b0, d0, d1, sq0, sq1, w1, ready}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready == 1'b1, "R1 ready after reset", {31'b0, ready}, 32'h1);

    valid = 1'b1;
    for (int i = 0; i < NV; i++) begin
      replay = VEC[i].rp; v0 = VEC[i].sv0; v1 = VEC[i].sv1;
      a0 = VEC[i].ia0; b0 = VEC[i].ib0; a1 = VEC[i].ia1; b1 = VEC[i].ib1;
      @(negedge clk);
      chk(d0 == VEC[i].ed0, $sformatf("R%0d vec%0d done0", VEC[i].req, i), {31'b0, d0}, {31'b0, VEC[i].ed0});
      chk(d1 == VEC[i].ed1, $sformatf("R%0d vec%0d done1", VEC[i].req, i), {31'b0, d1}, {31'b0, VEC[i].ed1});
      chk(sq0 == VEC[i].esq && sq1 == VEC[i].esq, $sformatf("R%0d vec%0d squash", VEC[i].req, i),
          {30'b0, sq0, sq1}, {30'b0, VEC[i].esq, VEC[i].esq});
      chk(w1 == VEC[i].ew, $sformatf("R%0d vec%0d wait1", VEC[i].req, i), {31'b0, w1}, {31'b0, VEC[i].ew});
      if (VEC[i].ed0 && !VEC[i].esq)
        chk(r0 == VEC[i].er0, $sformatf("R%0d vec%0d res0", VEC[i].req, i), r0, VEC[i].er0);
      if (VEC[i].ed1 && !VEC[i].esq)
        chk(r1 == VEC[i].er1, $sformatf("R%0d vec%0d res1", VEC[i].req, i), r1, VEC[i].er1);
    end

    // R10: valid packable slots but valid_i low -> nothing done
    valid = 1'b0; replay = 1'b0; v0 = 1'b1; v1 = 1'b1;
    a0 = 32'h2; b0 = 32'h2; a1 = 32'h3; b1 = 32'h3;
    @(negedge clk);
    chk(!d0 && !d1 && !sq0 && !w1, "R10 no accept", {28'b0, d0, d1, sq0, w1}, 32'h0);

    // R10: accept on the next cycle, result one cycle later
    valid = 1'b1;
    @(negedge clk);
    chk(d0 && d1 && r0 == 32'h4 && r1 == 32'h6, "R10 accept latency", r1, 32'h6);

    // R9: replay with only slot1 valid
    replay = 1'b1; v0 = 1'b0; v1 = 1'b1; a1 = 32'hFFFF_FFFF; b1 = 32'h1;
    @(negedge clk);
    chk(d1 && !d0 && !w1 && !sq1 && r1 == 32'h0, "R9 replay slot1", r1, 32'h0);

    // R1: asynchronous reset clears outputs
    valid = 1'b0;
    #1 rst_n = 1'b0;
    #1;
    chk({d0, d1, sq0, w1, ready} == 5'b0, "R1 async reset", {27'b0, d0, d1, sq0, w1, ready}, 32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule